// File: doc/BRIEF.md
# Home-Cluster Task Dispatcher

This block sits between a packet ordering engine and a set of processing clusters. Each incoming task names a message and gives the number of packet bytes that must be copied into a cluster's local buffer. The dispatcher keeps its own count of free buffer bytes and outstanding tasks for every cluster. It sends each task to one cluster and reports that choice for one cycle on its output.

The preferred target is the message's home cluster, which is the message ID modulo the number of clusters. This spreads messages evenly and keeps all packets of a message on one cluster while that cluster has room. When the home cluster cannot take the task, the task goes to the eligible cluster with the fewest outstanding tasks. When no cluster can take it, the dispatcher holds it by keeping `in_ready` low, and the producer must wait.

Clusters return credit through a per-cluster completion strobe that carries the byte count of the finished task. A completion and a dispatch may hit the same cluster in the same cycle.

Top module: `task_dispatcher`

## Requirements
- R1: After reset every cluster has `CAP_BYTES` free bytes and zero outstanding tasks, and `disp_valid` is low.
- R2: A cluster is eligible for the presented task when its free bytes are at least `in_bytes` and its outstanding count is below `MAX_OUT`. Both values are taken as registered at the start of the cycle, so a completion in the same cycle is not yet counted.
- R3: If the home cluster (`in_msg_id` modulo `N_CL`) is eligible, the task goes to it.
- R4: Otherwise the task goes to the eligible cluster with the smallest outstanding count. Ties go to the lowest cluster index.
- R5: `in_ready` is high exactly when at least one cluster is eligible for the presented task. A task larger than `CAP_BYTES` is never accepted.
- R6: A task accepted in cycle t (`in_valid` and `in_ready` both high) appears in cycle t+1 as a one-cycle `disp_valid` pulse. The pulse carries the chosen cluster index, the message ID and the byte count.
- R7: A dispatch subtracts its bytes from the chosen cluster's free space and adds one to that cluster's outstanding count. A completion adds `done_bytes` back and subtracts one. Both take effect together when they fall in the same cycle.
- R8: Free space never exceeds `CAP_BYTES`, and the outstanding count never exceeds `MAX_OUT`.
- R9: While `in_valid` is low, no dispatch is reported and no space is debited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Task presented |
| in_ready | output | 1 | Some cluster can take the presented task |
| in_msg_id | input | MSG_W | Message ID of the task |
| in_bytes | input | BYTE_W | Buffer bytes the task needs |
| disp_valid | output | 1 | One-cycle dispatch report |
| disp_cluster | output | IDX_W | Cluster chosen |
| disp_msg_id | output | MSG_W | Message ID dispatched |
| disp_bytes | output | BYTE_W | Bytes debited |
| done_valid | input | N_CL | Per-cluster task completion strobe |
| done_bytes | input | N_CL*BYTE_W | Bytes returned by each completion, cluster i in slice i |

## Verification
Some properties are checked on every cycle. The space and count bounds must hold, a debit must only land on a cluster that fits, the home cluster must win whenever it is eligible, and the chosen cluster must be eligible. An accepted task must produce exactly one report on the next cycle, and an idle input must produce none. The fallback order by load and index can only be shown by the bench's scenarios, which model space and load independently. So can the same-cycle credit and debit, the one-cycle delay before returned credit unblocks a stalled task, and the full restore of capacity after every task drains.

// File: rtl/disp_pkg.sv
package disp_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cluster_credit.sv
module cluster_credit #(
  parameter int CAP_BYTES = 2048,
  parameter int MAX_OUT   = 8,
  parameter int BYTE_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] need_bytes,
  input  logic              take,
  input  logic [BYTE_W-1:0] take_bytes,
  input  logic              give,
  input  logic [BYTE_W-1:0] give_bytes,
  output logic              fits,
  output logic [$clog2(MAX_OUT+1)-1:0] load
);
  localparam int SPACE_W = $clog2(CAP_BYTES + 1);
  localparam int CNT_W   = $clog2(MAX_OUT + 1);
  localparam int W       = ((SPACE_W > BYTE_W) ? SPACE_W : BYTE_W) + 1;

  logic [SPACE_W-1:0] free_q, free_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               upd_en;
  logic [W-1:0]       free_ext, need_ext, sum_ext;

  assign free_ext = W'(free_q);
  assign need_ext = W'(need_bytes);
  assign fits     = (free_ext >= need_ext) && (cnt_q < CNT_W'(MAX_OUT));
  assign load     = cnt_q;
  assign upd_en   = take | give;

  always_comb begin
    sum_ext = free_ext;
    if (take) sum_ext = sum_ext - W'(take_bytes);
    if (give) sum_ext = sum_ext + W'(give_bytes);
    free_d = SPACE_W'(sum_ext);
    cnt_d  = cnt_q;
    if (take && !give) cnt_d = cnt_q + CNT_W'(1);
    if (give && !take) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= SPACE_W'(CAP_BYTES);
      cnt_q  <= '0;
    end else if (upd_en) begin
      free_q <= free_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8: the accounting stays inside its limits
  assert_space_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= SPACE_W'(CAP_BYTES));
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_OUT));
  // R2: a debit only lands on a cluster that could hold it
  assert_take_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> fits);
  // R7: a lone completion lowers the load by one
  assert_give_drops_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/cluster_select.sv
module cluster_select #(
  parameter int N_CL  = 4,
  parameter int CNT_W = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic [N_CL-1:0]       elig,
  input  logic [N_CL*CNT_W-1:0] loads,
  input  logic [IDX_W-1:0]      home,
  output logic                  any,
  output logic [IDX_W-1:0]      sel
);
  logic [IDX_W-1:0] best_idx;
  logic [CNT_W-1:0] best_load;
  logic             found;

  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_load = '0;
    for (int i = 0; i < N_CL; i++) begin
      if (elig[i] && (!found || loads[i*CNT_W +: CNT_W] < best_load)) begin
        found     = 1'b1;
        best_idx  = IDX_W'(i);
        best_load = loads[i*CNT_W +: CNT_W];
      end
    end
  end

  assign any = found;
  assign sel = elig[home] ? home : best_idx;

  // R3: the home cluster wins whenever it is eligible
  assert_home_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && elig[home]) |-> (sel == home));
  // R2: the choice is always an eligible cluster
  assert_sel_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && any) |-> elig[sel]);
endmodule

// File: rtl/task_dispatcher.sv
module task_dispatcher #(
  parameter int N_CL      = 4,
  parameter int CAP_BYTES = 2048,
  parameter int MAX_OUT   = 8,
  parameter int MSG_W     = 9,
  parameter int BYTE_W    = 12,
  parameter int IDX_W     = disp_pkg::idx_width(N_CL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [MSG_W-1:0]       in_msg_id,
  input  logic [BYTE_W-1:0]      in_bytes,
  output logic                   disp_valid,
  output logic [IDX_W-1:0]       disp_cluster,
  output logic [MSG_W-1:0]       disp_msg_id,
  output logic [BYTE_W-1:0]      disp_bytes,
  input  logic [N_CL-1:0]        done_valid,
  input  logic [N_CL*BYTE_W-1:0] done_bytes
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [MSG_W-1:0] N_AS_MSG = MSG_W'(N_CL);

  logic [N_CL-1:0]       elig;
  logic [N_CL*CNT_W-1:0] loads;
  logic [IDX_W-1:0]      home, sel;
  logic                  any, fire;

  assign home     = IDX_W'(in_msg_id % N_AS_MSG);
  assign in_ready = any;
  assign fire     = in_valid & any;

  for (genvar g = 0; g < N_CL; g++) begin : g_cl
    logic [CNT_W-1:0] ld;
    cluster_credit #(
      .CAP_BYTES(CAP_BYTES), .MAX_OUT(MAX_OUT), .BYTE_W(BYTE_W)
    ) u_credit (
      .clk(clk), .rst_n(rst_n),
      .need_bytes(in_bytes),
      .take(fire && (sel == IDX_W'(g))),
      .take_bytes(in_bytes),
      .give(done_valid[g]),
      .give_bytes(done_bytes[g*BYTE_W +: BYTE_W]),
      .fits(elig[g]),
      .load(ld)
    );
    assign loads[g*CNT_W +: CNT_W] = ld;
  end

  cluster_select #(.N_CL(N_CL), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .req(in_valid),
    .elig(elig), .loads(loads), .home(home),
    .any(any), .sel(sel)
  );

  logic              dv_d;
  logic [IDX_W-1:0]  dc_d;
  logic [MSG_W-1:0]  dm_d;
  logic [BYTE_W-1:0] db_d;

  always_comb begin
    dv_d = fire;
    dc_d = disp_cluster;
    dm_d = disp_msg_id;
    db_d = disp_bytes;
    if (fire) begin
      dc_d = sel;
      dm_d = in_msg_id;
      db_d = in_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid   <= 1'b0;
      disp_cluster <= '0;
      disp_msg_id  <= '0;
      disp_bytes   <= '0;
    end else begin
      disp_valid   <= dv_d;
      disp_cluster <= dc_d;
      disp_msg_id  <= dm_d;
      disp_bytes   <= db_d;
    end
  end

  // R6: an accepted task is reported on the next cycle
  assert_report_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> disp_valid);
  // R9: no input, no report
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !disp_valid);
endmodule

// File: tb/task_dispatcher_test.sv
module task_dispatcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int CAP = 2048;
  localparam int MO = 8;
  localparam int MW = 9;
  localparam int BW = 12;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [MW-1:0] in_msg_id = '0;
  logic [BW-1:0] in_bytes = '0;
  logic disp_valid;
  logic [IW-1:0] disp_cluster;
  logic [MW-1:0] disp_msg_id;
  logic [BW-1:0] disp_bytes;
  logic [N-1:0] done_valid = '0;
  logic [N*BW-1:0] done_bytes = '0;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  int free_m [N];
  int outq [N][$];
  int exp_cl [$];
  int exp_msg [$];
  int exp_by [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  task_dispatcher uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_msg_id(in_msg_id), .in_bytes(in_bytes), .disp_valid(disp_valid),
    .disp_cluster(disp_cluster), .disp_msg_id(disp_msg_id), .disp_bytes(disp_bytes),
    .done_valid(done_valid), .done_bytes(done_bytes)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (exp_cl.size() == 0) begin
        chk(0, "R9 unexpected dispatch", 1, 0);
      end else begin
        int c, m, b;
        c = exp_cl.pop_front(); m = exp_msg.pop_front(); b = exp_by.pop_front();
        chk(int'(disp_cluster) == c, "R3/R4 cluster", int'(disp_cluster), c);
        chk(int'(disp_msg_id) == m, "R6 msg id", int'(disp_msg_id), m);
        chk(int'(disp_bytes) == b, "R6 bytes", int'(disp_bytes), b);
      end
    end
  end

  // one cycle: drive at negedge, predict, advance model, wait for posedge
  task automatic step(input bit v, input int msg, input int by,
                      input bit [N-1:0] dm, output bit acc);
    bit el [N];
    bit any;
    int sel, h;
    bit [N-1:0] dv;
    @(negedge clk);
    dv = '0;
    for (int i = 0; i < N; i++) begin
      if (dm[i] && outq[i].size() > 0) begin
        dv[i] = 1'b1;
        done_bytes[i*BW +: BW] = BW'(outq[i][0]);
      end
    end
    in_valid = v; in_msg_id = MW'(msg); in_bytes = BW'(by); done_valid = dv;
    #1;
    any = 0;
    for (int i = 0; i < N; i++) begin
      el[i] = (free_m[i] >= by) && (outq[i].size() < MO);
      any |= el[i];
    end
    chk(in_ready == any, "R5 ready", int'(in_ready), int'(any));
    acc = v && any;
    if (acc) begin
      h = msg % N;
      if (el[h]) sel = h;
      else begin
        sel = -1;
        for (int i = 0; i < N; i++)
          if (el[i] && (sel < 0 || outq[i].size() < outq[sel].size())) sel = i;
      end
    end
    for (int i = 0; i < N; i++)
      if (dv[i]) free_m[i] += outq[i].pop_front();
    if (acc) begin
      free_m[sel] -= by;
      outq[sel].push_back(by);
      exp_cl.push_back(sel); exp_msg.push_back(msg); exp_by.push_back(by);
    end
    @(posedge clk);
  endtask

  task automatic send(input int msg, input int by, input bit [N-1:0] dm);
    bit acc = 0;
    for (int k = 0; k < 50 && !acc; k++) step(1, msg, by, dm, acc);
    chk(acc, "R2 task accepted", int'(acc), 1);
  endtask

  task automatic idle(input int n, input bit [N-1:0] dm);
    bit acc;
    for (int k = 0; k < n; k++) step(0, 0, 0, dm, acc);
  endtask

  initial begin
    for (int i = 0; i < N; i++) free_m[i] = CAP;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(disp_valid == 1'b0, "R1 reset disp_valid", int'(disp_valid), 0);
    begin
      bit acc;
      // R1: full capacity accepted right after reset
      step(1, 2, CAP, '0, acc);
      chk(acc, "R1 full capacity after reset", int'(acc), 1);
    end
    idle(2, 4'b0100);
    // R3: messages land on their home clusters
    for (int m = 0; m < 8; m++) send(m, 100, '0);
    // R4: home full -> least loaded, lowest index on ties
    send(1, 1800, '0);
    send(5, 100, '0);
    send(9, 100, '0);
    send(13, 100, '0);
    // R7: dispatch and completion on the same cluster in one cycle
    send(1, 40, 4'b0010);
    // R2: outstanding cap forces fallback
    for (int k = 0; k < 9; k++) send(3, 10, '0);
    // R5: oversize task is held and never reported
    begin
      bit acc;
      for (int k = 0; k < 3; k++) begin
        step(1, 0, 3000, '0, acc);
        chk(!acc, "R5 oversize held", int'(acc), 0);
      end
    end
    idle(2, '0); // R9: idle cycles produce nothing
    // R2: fill space, stall, then release through completions
    for (int k = 0; k < 4; k++) begin
      bit acc;
      step(1, k, 1700, '0, acc);
    end
    send(2, 1900, 4'b1111);
    idle(40, 4'b1111);
    // R7: every cluster back to full capacity after draining
    for (int m = 0; m < N; m++) send(m, CAP, '0);
    idle(4, '0);
    idle(10, 4'b1111);
    idle(3, '0);
    chk(exp_cl.size() == 0, "R6 all reports seen", exp_cl.size(), 0);
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule